// File: doc/BRIEF.md
# Masked Binary CAM with Lowest-Address Priority Encoder

This block is a synchronous, single-port binary content-addressable memory. It holds `WORDS` entries of `BITS` bits, and each entry carries its own valid flag. On every rising clock edge, a small operation decoder looks at the select, write and search enables and picks one of four operations:

| Operation | What it does |
|-----------|--------------|
| `OP_IDLE` | nothing (standby) |
| `OP_WRITE` | stores data and a valid flag at an address |
| `OP_READ` | returns an entry and its valid flag |
| `OP_SEARCH` | compares every entry at once against a masked pattern |

A search gives two results: a global hit flag and the lowest-numbered matching address. Both appear on registered outputs one cycle after the edge. Read results appear on registered outputs with the same one-cycle latency.

An active-low asynchronous reset clears every valid flag and the output registers without waiting for the clock. While the reset is low, no access can take place. Two active-low output enables stand in for three-state drivers, and both act without the clock. Each one gates a group of outputs to zero and drops a matching drive-enable flag. One enable covers the read data and read valid outputs. The other covers the match address output.

The decoder has no stored state. Each cycle it maps the control inputs to one of the four operations:
- `OP_SEARCH` whenever select and search enable are both low.
- Otherwise `OP_WRITE` or `OP_READ`, depending on the write enable.
- `OP_IDLE` whenever select is high or reset is low.

The output process then updates the result registers for that operation. `OP_WRITE` and `OP_IDLE` leave them unchanged.

Top module: `cam_masked_pe`

## Requirements
- R1: A write happens when, at a rising clock edge, `cs_n`=0, `we_n`=0, `cmp_en_n`=1 and `rst_n`=1. It stores `wr_data` and sets the entry's valid flag to `wr_valid` at `addr`.
- R2: A write cycle leaves `rd_data`, `rd_valid`, `match_addr` and `hit` unchanged.
- R3: A read happens when, at a rising clock edge, `cs_n`=0, `we_n`=1, `cmp_en_n`=1 and `rst_n`=1. After that edge, `rd_data` and `rd_valid` show the entry at `addr`.
- R4: A search happens when, at a rising clock edge, `cs_n`=0 and `cmp_en_n`=0. A bit where `cmp_mask` is 0 always matches. A bit where `cmp_mask` is 1 matches only when the stored bit equals `cmp_data`.
- R5: An entry whose valid flag is 0 never matches a search.
- R6: When one or more entries match, `hit` becomes 1 after the edge and `match_addr` holds the lowest matching index.
- R7: When a search finds no match, `hit` becomes 0 and `match_addr` becomes all zeros.
- R8: A falling `rst_n` at once clears every valid flag and the output registers. While `rst_n` is 0, no write, read or search takes place. Stored data words are kept.
- R9: With `cs_n`=1, the stored contents and all outputs stay unchanged.
- R10: With `data_oe_n`=1, `rd_data` and `rd_valid` read 0 and `rd_drive` is 0, without waiting for the clock. With `data_oe_n`=0, the registered values show and `rd_drive` is 1.
- R11: With `addr_oe_n`=1, `match_addr` reads 0 and `match_drive` is 0, without waiting for the clock. With `addr_oe_n`=0, the registered value shows and `match_drive` is 1.
- R12: When `cmp_en_n`=0 and `cs_n`=0, the search takes priority and any write request in the same cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low clear of valid flags and outputs |
| cs_n | input | 1 | Active-low select; high means standby |
| we_n | input | 1 | Active-low write enable (0 = write, 1 = read) |
| cmp_en_n | input | 1 | Active-low search enable |
| data_oe_n | input | 1 | Active-low enable for read data and read valid |
| addr_oe_n | input | 1 | Active-low enable for the match address |
| addr | input | clog2(WORDS) | Entry index for read and write |
| wr_data | input | BITS | Data to store |
| wr_valid | input | 1 | Valid flag to store |
| cmp_data | input | BITS | Search pattern |
| cmp_mask | input | BITS | Search mask (1 = compare this bit) |
| rd_data | output | BITS | Registered read data, zero when disabled |
| rd_valid | output | 1 | Registered read valid flag, zero when disabled |
| rd_drive | output | 1 | High while read outputs are enabled |
| match_addr | output | clog2(WORDS) | Lowest matching index, zero when disabled or on a miss |
| match_drive | output | 1 | High while the match address is enabled |
| hit | output | 1 | Registered global match flag |

## Verification
The bench builds the block with 8 entries of 8 bits. With only 8 entries, every index fits in a three-bit field, so a few writes can place two valid matches, an invalid copy and a partial-mask match side by side. This small size also makes the all-entries-match case and the lowest-index tie-break cheap to reach. A full-width mask of zeros then shows the priority encoder picking the lowest valid index among all entries.

// File: rtl/cam_pkg.sv
package cam_pkg;

    typedef enum logic [1:0] {
        OP_IDLE   = 2'd0,
        OP_WRITE  = 2'd1,
        OP_READ   = 2'd2,
        OP_SEARCH = 2'd3
    } cam_op_e;

endpackage

// File: rtl/cam_op_decode.sv
module cam_op_decode
    import cam_pkg::*;
(
    input  logic    rst_n,
    input  logic    cs_n,
    input  logic    we_n,
    input  logic    cmp_en_n,
    output cam_op_e op
);

    always_comb begin
        if (!rst_n || cs_n)
            op = OP_IDLE;
        else if (!cmp_en_n)
            op = OP_SEARCH;
        else if (!we_n)
            op = OP_WRITE;
        else
            op = OP_READ;
    end

endmodule

// File: rtl/cam_store.sv
module cam_store #(
    parameter int WORDS = 64,
    parameter int BITS  = 32,
    localparam int AW   = $clog2(WORDS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [BITS-1:0] wr_data,
    input  logic            wr_valid,
    output logic [BITS-1:0] mem_o [WORDS],
    output logic [WORDS-1:0] valid_o
);

    logic [BITS-1:0]  mem_q [WORDS];
    logic [WORDS-1:0] valid_q;

    // Data words keep their contents across reset.
    always_ff @(posedge clk) begin
        if (wr_en)
            mem_q[wr_addr] <= wr_data;
    end

    // Valid flags clear asynchronously.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            valid_q <= '0;
        else if (wr_en)
            valid_q[wr_addr] <= wr_valid;
    end

    assign mem_o   = mem_q;
    assign valid_o = valid_q;

endmodule

// File: rtl/cam_match_enc.sv
module cam_match_enc #(
    parameter int WORDS = 64,
    parameter int BITS  = 32,
    localparam int AW   = $clog2(WORDS)
) (
    input  logic [BITS-1:0]  mem_i [WORDS],
    input  logic [WORDS-1:0] valid_i,
    input  logic [BITS-1:0]  key,
    input  logic [BITS-1:0]  care,
    output logic             any_match,
    output logic [AW-1:0]    first_idx
);

    logic [WORDS-1:0] line_hit;

    genvar g;
    generate
        for (g = 0; g < WORDS; g++) begin : g_line
            assign line_hit[g] = valid_i[g] && (((mem_i[g] ^ key) & care) == '0);
        end
    endgenerate

    // Scan from the top down so the lowest matching index is the one kept.
    always_comb begin
        first_idx = '0;
        for (int i = WORDS - 1; i >= 0; i--) begin
            if (line_hit[i])
                first_idx = AW'(i);
        end
    end

    assign any_match = |line_hit;

endmodule

// File: rtl/cam_masked_pe.sv
module cam_masked_pe
    import cam_pkg::*;
#(
    parameter int WORDS = 64,
    parameter int BITS  = 32,
    localparam int AW   = $clog2(WORDS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cs_n,
    input  logic            we_n,
    input  logic            cmp_en_n,
    input  logic            data_oe_n,
    input  logic            addr_oe_n,
    input  logic [AW-1:0]   addr,
    input  logic [BITS-1:0] wr_data,
    input  logic            wr_valid,
    input  logic [BITS-1:0] cmp_data,
    input  logic [BITS-1:0] cmp_mask,
    output logic [BITS-1:0] rd_data,
    output logic            rd_valid,
    output logic            rd_drive,
    output logic [AW-1:0]   match_addr,
    output logic            match_drive,
    output logic            hit
);

    cam_op_e          op;
    logic [BITS-1:0]  mem [WORDS];
    logic [WORDS-1:0] valid;
    logic             any_match;
    logic [AW-1:0]    first_idx;

    logic [BITS-1:0]  rd_data_q, rd_data_d;
    logic             rd_valid_q, rd_valid_d;
    logic [AW-1:0]    maddr_q, maddr_d;
    logic             hit_q, hit_d;

    cam_op_decode u_dec (
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .we_n     (we_n),
        .cmp_en_n (cmp_en_n),
        .op       (op)
    );

    cam_store #(.WORDS(WORDS), .BITS(BITS)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (op == OP_WRITE),
        .wr_addr  (addr),
        .wr_data  (wr_data),
        .wr_valid (wr_valid),
        .mem_o    (mem),
        .valid_o  (valid)
    );

    cam_match_enc #(.WORDS(WORDS), .BITS(BITS)) u_match (
        .mem_i     (mem),
        .valid_i   (valid),
        .key       (cmp_data),
        .care      (cmp_mask),
        .any_match (any_match),
        .first_idx (first_idx)
    );

    // Next-state logic for the result registers.
    always_comb begin
        rd_data_d  = rd_data_q;
        rd_valid_d = rd_valid_q;
        maddr_d    = maddr_q;
        hit_d      = hit_q;
        unique case (op)
            OP_IDLE, OP_WRITE: ;
            OP_READ: begin
                rd_data_d  = mem[addr];
                rd_valid_d = valid[addr];
            end
            OP_SEARCH: begin
                hit_d   = any_match;
                maddr_d = any_match ? first_idx : '0;
            end
        endcase
    end

    // Result register update.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data_q  <= '0;
            rd_valid_q <= 1'b0;
            maddr_q    <= '0;
            hit_q      <= 1'b0;
        end else begin
            rd_data_q  <= rd_data_d;
            rd_valid_q <= rd_valid_d;
            maddr_q    <= maddr_d;
            hit_q      <= hit_d;
        end
    end

    // Output enables gate the registered values without waiting for the clock.
    assign rd_drive    = !data_oe_n;
    assign match_drive = !addr_oe_n;
    assign rd_data     = rd_drive ? rd_data_q : '0;
    assign rd_valid    = rd_drive & rd_valid_q;
    assign match_addr  = match_drive ? maddr_q : '0;
    assign hit         = hit_q;

endmodule

// File: rtl/cam_masked_pe_chk.sv
module cam_masked_pe_chk #(
    parameter int AW = 6,
    parameter int BW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cs_n,
    input logic          we_n,
    input logic          cmp_en_n,
    input logic          data_oe_n,
    input logic          addr_oe_n,
    input logic [BW-1:0] rd_data,
    input logic          rd_valid,
    input logic          rd_drive,
    input logic [AW-1:0] match_addr,
    input logic          match_drive,
    input logic          hit
);

    a_r2_write_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !we_n && cmp_en_n) |=>
            ($stable(hit) && (!$stable(data_oe_n) || ($stable(rd_data) && $stable(rd_valid)))
                          && (!$stable(addr_oe_n) || $stable(match_addr))));

    a_r9_standby_holds: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=>
            ($stable(hit) && (!$stable(data_oe_n) || ($stable(rd_data) && $stable(rd_valid)))
                          && (!$stable(addr_oe_n) || $stable(match_addr))));

    a_r7_miss_zero_addr: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (match_addr == '0));

    a_r10_data_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe_n |-> (!rd_drive && rd_data == '0 && !rd_valid));

    a_r11_addr_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        addr_oe_n |-> (!match_drive && match_addr == '0));

endmodule

bind cam_masked_pe cam_masked_pe_chk #(.AW(AW), .BW(BITS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_n        (cs_n),
    .we_n        (we_n),
    .cmp_en_n    (cmp_en_n),
    .data_oe_n   (data_oe_n),
    .addr_oe_n   (addr_oe_n),
    .rd_data     (rd_data),
    .rd_valid    (rd_valid),
    .rd_drive    (rd_drive),
    .match_addr  (match_addr),
    .match_drive (match_drive),
    .hit         (hit)
);

// File: tb/cam_masked_pe_tb_top.sv
`timescale 1ns/1ps
module cam_masked_pe_tb_top;

    localparam int W  = 8;
    localparam int B  = 8;
    localparam int AW = 3;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n, cs_n, we_n, cmp_en_n, data_oe_n, addr_oe_n, wr_valid;
    logic [AW-1:0] addr;
    logic [B-1:0]  wr_data, cmp_data, cmp_mask;
    logic [B-1:0]  rd_data;
    logic          rd_valid, rd_drive, match_drive, hit;
    logic [AW-1:0] match_addr;

    cam_masked_pe #(.WORDS(W), .BITS(B)) dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .cmp_en_n(cmp_en_n),
        .data_oe_n(data_oe_n), .addr_oe_n(addr_oe_n), .addr(addr),
        .wr_data(wr_data), .wr_valid(wr_valid), .cmp_data(cmp_data), .cmp_mask(cmp_mask),
        .rd_data(rd_data), .rd_valid(rd_valid), .rd_drive(rd_drive),
        .match_addr(match_addr), .match_drive(match_drive), .hit(hit)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // op: 0 idle, 1 write, 2 read, 3 search
    typedef struct packed {
        logic [1:0] op;
        logic [2:0] a;
        logic [7:0] d;
        logic       v;
        logic [7:0] m;
        logic [7:0] ed;
        logic       ef;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{2'd1, 3'd2, 8'h5A, 1'b1, 8'h00, 8'h00, 1'b0, 4'd1},  // R1 write
        '{2'd1, 3'd5, 8'h5A, 1'b1, 8'h00, 8'h00, 1'b0, 4'd1},  // R1 write
        '{2'd1, 3'd6, 8'hF0, 1'b0, 8'h00, 8'h00, 1'b0, 4'd1},  // R1 write invalid
        '{2'd1, 3'd7, 8'h3C, 1'b1, 8'h00, 8'h00, 1'b0, 4'd1},  // R1 write
        '{2'd2, 3'd2, 8'h00, 1'b0, 8'h00, 8'h5A, 1'b1, 4'd3},  // R3 read
        '{2'd2, 3'd6, 8'h00, 1'b0, 8'h00, 8'hF0, 1'b0, 4'd3},  // R3 read invalid
        '{2'd0, 3'd0, 8'h00, 1'b0, 8'h00, 8'h00, 1'b0, 4'd9},  // R9 standby
        '{2'd3, 3'd0, 8'h5A, 1'b0, 8'hFF, 8'h02, 1'b1, 4'd6},  // R6 two matches, lowest
        '{2'd3, 3'd0, 8'hF0, 1'b0, 8'hFF, 8'h00, 1'b0, 4'd5},  // R5 only invalid copy
        '{2'd3, 3'd0, 8'h30, 1'b0, 8'hF0, 8'h07, 1'b1, 4'd4},  // R4 upper nibble
        '{2'd3, 3'd0, 8'h00, 1'b0, 8'h00, 8'h02, 1'b1, 4'd4},  // R4 mask all zero
        '{2'd1, 3'd2, 8'h5A, 1'b0, 8'h00, 8'h00, 1'b0, 4'd1},  // R1 invalidate
        '{2'd3, 3'd0, 8'h5A, 1'b0, 8'hFF, 8'h05, 1'b1, 4'd5},  // R5 skip invalidated
        '{2'd3, 3'd0, 8'h5B, 1'b0, 8'hFE, 8'h05, 1'b1, 4'd4},  // R4 bit0 masked
        '{2'd3, 3'd0, 8'h77, 1'b0, 8'hFF, 8'h00, 1'b0, 4'd7}   // R7 miss
    };

    task automatic drive(input logic [1:0] op, input logic [2:0] a, input logic [7:0] d,
                         input logic v, input logic [7:0] m);
        cs_n     = (op == 2'd0);
        we_n     = (op != 2'd1);
        cmp_en_n = (op != 2'd3);
        addr     = a;
        wr_data  = d;
        wr_valid = v;
        cmp_data = d;
        cmp_mask = m;
    endtask

    task automatic cycle();
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; data_oe_n = 1'b0; addr_oe_n = 1'b0;
        drive(2'd0, 3'd0, 8'h00, 1'b0, 8'h00);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R8 reset state
        check(rd_data == 0 && !rd_valid && !hit && match_addr == 0, "R8", "reset outputs",
              {rd_data, rd_valid, hit, match_addr}, 0);

        for (int i = 0; i < NV; i++) begin
            logic [7:0] p_d; logic p_v, p_h; logic [2:0] p_a;
            @(negedge clk);
            p_d = rd_data; p_v = rd_valid; p_h = hit; p_a = match_addr;
            drive(VECS[i].op, VECS[i].a, VECS[i].d, VECS[i].v, VECS[i].m);
            cycle();
            case (VECS[i].op)
                2'd1: check(rd_data == p_d && rd_valid == p_v && hit == p_h && match_addr == p_a,
                            "R2", "write keeps outputs", {rd_data, rd_valid, hit, match_addr},
                            {p_d, p_v, p_h, p_a});
                2'd0: check(rd_data == p_d && rd_valid == p_v && hit == p_h && match_addr == p_a,
                            "R9", "standby keeps outputs", {rd_data, rd_valid, hit, match_addr},
                            {p_d, p_v, p_h, p_a});
                2'd2: check(rd_data == VECS[i].ed && rd_valid == VECS[i].ef,
                            $sformatf("R%0d", VECS[i].req), "read", {rd_data, rd_valid},
                            {VECS[i].ed, VECS[i].ef});
                default: check(hit == VECS[i].ef && match_addr == VECS[i].ed[2:0],
                            $sformatf("R%0d", VECS[i].req), "search", {hit, match_addr},
                            {VECS[i].ef, VECS[i].ed[2:0]});
            endcase
        end

        // R12: write and search requested together; search wins, write dropped
        @(negedge clk);
        drive(2'd3, 3'd0, 8'h5A, 1'b1, 8'hFF);
        we_n = 1'b0;
        cycle();
        check(hit && match_addr == 3'd5, "R12", "search wins", {hit, match_addr}, {1'b1, 3'd5});
        @(negedge clk);
        drive(2'd2, 3'd0, 8'h00, 1'b0, 8'h00);
        cycle();
        check(!rd_valid, "R12", "write ignored", rd_valid, 0);

        // R10: data output enable acts mid-cycle
        @(negedge clk);
        drive(2'd2, 3'd5, 8'h00, 1'b0, 8'h00);
        cycle();
        #1 data_oe_n = 1'b1;
        #0.5;
        check(rd_data == 0 && !rd_valid && !rd_drive, "R10", "data disabled",
              {rd_data, rd_valid, rd_drive}, 0);
        data_oe_n = 1'b0;
        #0.5;
        check(rd_data == 8'h5A && rd_valid && rd_drive, "R10", "data enabled",
              {rd_data, rd_valid, rd_drive}, {8'h5A, 1'b1, 1'b1});

        // R11: address output enable acts mid-cycle
        @(negedge clk);
        drive(2'd3, 3'd0, 8'h3C, 1'b0, 8'hFF);
        cycle();
        #1 addr_oe_n = 1'b1;
        #0.5;
        check(match_addr == 0 && !match_drive && hit, "R11", "addr disabled",
              {match_addr, match_drive, hit}, {3'd0, 1'b0, 1'b1});
        addr_oe_n = 1'b0;
        #0.5;
        check(match_addr == 3'd7 && match_drive, "R11", "addr enabled",
              {match_addr, match_drive}, {3'd7, 1'b1});

        // R8: asynchronous reset mid-cycle
        #0.5 rst_n = 1'b0;
        #0.2;
        check(!hit && match_addr == 0, "R8", "async clear", {hit, match_addr}, 0);
        @(negedge clk);
        drive(2'd1, 3'd3, 8'h11, 1'b1, 8'h00);  // blocked while reset low
        cycle();
        @(negedge clk);
        rst_n = 1'b1;
        drive(2'd3, 3'd0, 8'h00, 1'b0, 8'h00);
        cycle();
        check(!hit && match_addr == 0, "R8", "all invalid, write blocked", {hit, match_addr}, 0);
        @(negedge clk);
        drive(2'd2, 3'd5, 8'h00, 1'b0, 8'h00);
        cycle();
        check(rd_data == 8'h5A && !rd_valid, "R8", "data kept, valid cleared",
              {rd_data, rd_valid}, {8'h5A, 1'b0});

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule